// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter with Underflow Repeat

This block sends host-supplied words out on a single serial data line, one word per frame. A host writes a word into a holding register. When a frame-sync pulse arrives on a serial-clock tick, the word moves from the holding register into a shift register. It then leaves the block most-significant bit first, one bit per serial-clock tick. The serial clock is modelled as an enable strobe `sclk_en` in the system clock domain. The frame-sync input is only looked at on cycles where that strobe is high.

The host is not required to keep pace with the frames, and the block handles three error cases:

- **Overwrite.** A second write before the copy replaces the pending word. The replaced word is never sent.
- **Underflow.** A frame sync with nothing new pending sends the previous word again. This repeats on every frame until the host writes. The active-low `xempty_n` flag reads 0 while nothing new is pending.
- **Early frame sync.** A frame sync that arrives before the current word has finished is unexpected when `fs_ignore` is 0. It sets a sticky `sync_err` flag and restarts transmission from the first bit with the newest word in the holding register. With `fs_ignore` at 1, the early pulse is dropped and the word in flight completes.

The host write port is a valid/ready stream, but it never applies back-pressure. `wr_ready` is held at 1 whenever the block is out of reset. A beat is accepted on every cycle with `wr_valid` high. The newest accepted beat always wins, which is how the overwrite case arises.

Top module: `fsync_ser_tx`

## Requirements
- R1: While `rst_n` is low, the outputs are `sdo`=0, `xempty_n`=0, `sync_err`=0 and `busy`=0.
- R2: `wr_ready` is 1 out of reset. A cycle with `wr_valid`=1 stores `wr_data`, and `xempty_n` reads 1 from the next cycle on.
- R3: A frame sync on a tick while idle copies the held word. After that edge, `sdo` shows bit WORD_W-1, and each later tick advances one bit toward bit 0. The tick after the bit-0 tick returns `sdo` to 0 and `busy` to 0, unless that tick carries a new frame sync. `xempty_n` reads 0 after the copy.
- R4: When several writes occur before a copy, only the last written word is transmitted.
- R5: A frame sync with no write since the last copy retransmits the previous word, on every such frame, and `xempty_n` stays 0.
- R6: With `fs_ignore`=0, a frame sync on a tick while bit index 0..WORD_W-2 of the word is on the line sets `sync_err`. It also restarts transmission at bit WORD_W-1 of the word currently in the holding register, which is a new word if one was written and otherwise the same word.
- R7: With `fs_ignore`=1, such an early frame sync leaves `sync_err` at 0 and the current word completes unchanged. A pending new word stays pending with `xempty_n`=1.
- R8: `sync_err` stays 1 until a cycle with `sync_err_clr`=1 or a reset, and reads 0 after that cycle.
- R9: A frame sync on the tick that ends bit 0 is not early. It loads the next word back to back with no error.
- R10: A write in the same cycle as an accepted frame sync does not reach that frame. The copy takes the previously held word, and the new word stays pending with `xempty_n`=1.
- R11: On cycles with `sclk_en`=0, `sdo` and `busy` keep their values and `fsync` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, also the transmitter reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Host write ready, 1 out of reset |
| wr_data | input | WORD_W | Host word |
| fs_ignore | input | 1 | 1: early frame syncs are dropped |
| sync_err_clr | input | 1 | Clears the sync-error flag |
| sclk_en | input | 1 | Serial clock tick strobe |
| fsync | input | 1 | Frame sync, sampled on ticks |
| sdo | output | 1 | Serial data out, MSB first |
| xempty_n | output | 1 | Active low: 0 when no new word is pending |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |
| busy | output | 1 | A word is on the line |

## Verification
The host write and the frame-sync copy can land in the same clock cycle. The bench provokes this from idle with one cycle that carries both a write beat and a frame-sync tick. It then judges that the line shows the older word's MSB, that `xempty_n` stays 1, and that the following frame carries the newly written word (R10).

A second collision is an early frame sync that meets a pending new word. The bench sweeps every early bit position with `fs_ignore` at both values. It compares each serial bit against shifts of the written words computed in the bench.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

  // Per-tick action the frame controller hands to the shift register
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2,
    ACT_STOP  = 2'd3
  } tx_act_e;

endpackage

// File: rtl/fstx_hold.sv
module fstx_hold #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic [WORD_W-1:0] word,
  output logic              fresh
);

  // A write always lands; a copy in the same cycle sees the old word and
  // leaves the new one pending.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word  <= '0;
      fresh <= 1'b0;
    end else if (wr_valid) begin
      word  <= wr_data;
      fresh <= 1'b1;
    end else if (take) begin
      fresh <= 1'b0;
    end
  end

  a_r2_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> fresh);

  a_r5_copy_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    take && !wr_valid |=> !fresh);

endmodule

// File: rtl/fstx_ctrl.sv
module fstx_ctrl
  import fstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    fsync,
  input  logic    fs_ignore,
  input  logic    err_clr,
  output tx_act_e act,
  output logic    busy,
  output logic    sync_err
);

  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt;
  logic             last_bit;
  logic             fs_accept;
  logic             fs_early;

  assign last_bit  = (cnt == LAST_IDX);
  assign fs_early  = tick && fsync && busy && !last_bit && !fs_ignore;
  assign fs_accept = tick && fsync && (!busy || last_bit || !fs_ignore);

  always_comb begin
    if (!tick)          act = ACT_HOLD;
    else if (fs_accept) act = ACT_LOAD;
    else if (busy)      act = last_bit ? ACT_STOP : ACT_SHIFT;
    else                act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      case (act)
        ACT_LOAD:  begin busy <= 1'b1; cnt <= '0; end
        ACT_SHIFT: cnt <= cnt + 1'b1;
        ACT_STOP:  begin busy <= 1'b0; cnt <= '0; end
        default:   ;
      endcase
    end
  end

  // Set wins over clear
  always_ff @(posedge clk) begin
    if (!rst_n)        sync_err <= 1'b0;
    else if (fs_early) sync_err <= 1'b1;
    else if (err_clr)  sync_err <= 1'b0;
  end

  a_r7_ignored_sync_advances: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && fsync && fs_ignore && !last_bit
      |=> busy && cnt == CNT_W'($past(cnt) + 1'b1) && !$rose(sync_err));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err && !err_clr |=> sync_err);

  a_r6_restart_at_msb: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && fsync && !fs_ignore && !last_bit |=> busy && cnt == '0);

  a_r9_back_to_back_clean: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && fsync && last_bit && !sync_err |=> busy && !sync_err);

endmodule

// File: rtl/fstx_shift.sv
module fstx_shift
  import fstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tx_act_e           act,
  input  logic [WORD_W-1:0] word,
  output logic              msb
);

  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
    end else begin
      case (act)
        ACT_LOAD:  sreg <= word;
        ACT_SHIFT: sreg <= {sreg[WORD_W-2:0], 1'b0};
        ACT_STOP:  sreg <= '0;
        default:   ;
      endcase
    end
  end

  assign msb = sreg[WORD_W-1];

  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_SHIFT |=> sreg[WORD_W-1] == $past(sreg[WORD_W-2]));

endmodule

// File: rtl/fsync_ser_tx.sv
module fsync_ser_tx
  import fstx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              fs_ignore,
  input  logic              sync_err_clr,
  input  logic              sclk_en,
  input  logic              fsync,
  output logic              sdo,
  output logic              xempty_n,
  output logic              sync_err,
  output logic              busy
);

  tx_act_e           act;
  logic [WORD_W-1:0] held;
  logic              fresh;
  logic              msb;

  assign wr_ready = rst_n;

  fstx_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .take     (act == ACT_LOAD),
    .word     (held),
    .fresh    (fresh)
  );

  fstx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sclk_en),
    .fsync     (fsync),
    .fs_ignore (fs_ignore),
    .err_clr   (sync_err_clr),
    .act       (act),
    .busy      (busy),
    .sync_err  (sync_err)
  );

  fstx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .word  (held),
    .msb   (msb)
  );

  assign sdo      = busy & msb;
  assign xempty_n = fresh;

  a_r11_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_en |=> $stable(sdo) && $stable(busy));

endmodule

// File: tb/fsync_ser_tx_tb.sv
module fsync_ser_tx_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [W-1:0] wr_data = '0;
  logic         fs_ignore = 1'b0;
  logic         sync_err_clr = 1'b0;
  logic         sclk_en = 1'b0;
  logic         fsync = 1'b0;
  logic         sdo, xempty_n, sync_err, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fsync_ser_tx #(.WORD_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .fs_ignore(fs_ignore), .sync_err_clr(sync_err_clr),
    .sclk_en(sclk_en), .fsync(fsync), .sdo(sdo), .xempty_n(xempty_n),
    .sync_err(sync_err), .busy(busy)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act_v, exp_v, $time);
    end
  endtask

  // One clock with the given inputs; returns 1 ns after the edge
  task automatic step(input bit v, input int d, input bit en, input bit fs);
    wr_valid = v; wr_data = W'(d); sclk_en = en; fsync = fs;
    @(posedge clk); #1;
    wr_valid = 1'b0; sclk_en = 1'b0; fsync = 1'b0; sync_err_clr = 1'b0;
  endtask

  function automatic int bitof(input int d, input int idx);
    return (d >> (W - 1 - idx)) & 1;
  endfunction

  // Word d is on the line at bit index from; walk the rest and the stop tick
  task automatic walk(input int d, input int from, input string req);
    for (int k = from; k < W; k++) begin
      if (k > from) step(0, 0, 1, 0);
      check(req, sdo, bitof(d, k));
      check(req, busy, 1);
    end
    step(0, 0, 1, 0);
    check(req, busy, 0);
    check(req, sdo, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", sdo, 0); check("R1", xempty_n, 0);
    check("R1", sync_err, 0); check("R1", busy, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    check("R2", wr_ready, 1);

    // R2 R3 R5: each word, then two underflow repeats
    for (int d = 0; d < (1 << W); d++) begin
      step(1, d, 0, 0);
      check("R2", xempty_n, 1);
      step(0, 0, 1, 1);
      check("R3", xempty_n, 0);
      walk(d, 0, "R3");
      for (int r = 0; r < 2; r++) begin
        step(0, 0, 1, 1);
        check("R5", xempty_n, 0);
        walk(d, 0, "R5");
      end
    end

    // R4 overwrite before copy
    step(1, 5, 0, 0);
    step(1, 10, 0, 0);
    step(1, 12, 0, 0);
    step(0, 0, 1, 1);
    walk(12, 0, "R4");

    // R6 R7 R8: early frame sync at every legal position, both settings
    for (int ig = 0; ig < 2; ig++) begin
      for (int p = 0; p <= W - 2; p++) begin
        for (int a = 1; a < (1 << W); a += 5) begin
          int b;
          b = (a ^ 4'hF) & ((1 << W) - 1);
          fs_ignore = ig[0];
          step(1, a, 0, 0);
          step(0, 0, 1, 1);
          for (int k = 1; k <= p; k++) step(0, 0, 1, 0);
          check("R3", sdo, bitof(a, p));
          step(1, b, 0, 0);
          step(0, 0, 1, 1);
          if (ig == 0) begin
            check("R6", sync_err, 1);
            walk(b, 0, "R6");
            check("R6", xempty_n, 0);
            step(0, 0, 0, 0);
            check("R8", sync_err, 1);
            sync_err_clr = 1'b1;
            step(0, 0, 0, 0);
            check("R8", sync_err, 0);
          end else begin
            check("R7", sync_err, 0);
            walk(a, p + 1, "R7");
            check("R7", xempty_n, 1);
            check("R7", sync_err, 0);
            step(0, 0, 1, 1);
            walk(b, 0, "R7");
          end
        end
      end
    end
    fs_ignore = 1'b0;

    // R6 early sync with nothing new restarts the same word
    step(1, 9, 0, 0);
    step(0, 0, 1, 1);
    step(0, 0, 1, 0);
    step(0, 0, 1, 1);
    check("R6", sync_err, 1);
    walk(9, 0, "R6");
    sync_err_clr = 1'b1;
    step(0, 0, 0, 0);
    check("R8", sync_err, 0);

    // R9 back-to-back frames
    step(1, 3, 0, 0);
    step(0, 0, 1, 1);
    for (int k = 1; k < W; k++) step(0, 0, 1, 0);
    step(1, 13, 0, 0);
    step(0, 0, 1, 1);
    check("R9", sync_err, 0);
    walk(13, 0, "R9");

    // R10 write and copy in the same cycle
    step(1, 6, 0, 0);
    step(0, 0, 1, 1);
    walk(6, 0, "R10");
    step(1, 11, 1, 1);
    check("R10", sdo, bitof(6, 0));
    check("R10", xempty_n, 1);
    walk(6, 0, "R10");
    step(0, 0, 1, 1);
    walk(11, 0, "R10");

    // R11 fsync without tick is ignored; line holds without ticks
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    check("R11", busy, 0);
    step(1, 8, 0, 0);
    step(0, 0, 1, 1);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 1);
      check("R11", sdo, bitof(8, 0));
      check("R11", busy, 1);
    end
    walk(8, 0, "R11");

    finish_run();
  end

endmodule